// File: doc/BRIEF.md
# PCI DMA Address Window Translator

This block sits on the inbound side of a PCI host bridge and turns the bus address of each DMA request into a system memory address. It compares every single-address-cycle request in parallel against four programmable target windows. Each window is described by a base, a size mask and a translated base. A window either maps the request directly onto memory, or points into a scatter-gather page table, in which case the block returns the address of the page-table entry to fetch. Dual-address-cycle requests go to a separate fixed window. That window passes the low 35 address bits straight through when the upper address bits carry the expected tag.

Software programs the windows through a simple write port. The result appears one clock after a request is presented. The result is either a hit, with the winning window index and the translated address, or a miss, with every other output at zero. Fetching page-table entries, caching translations and the bus protocol belong to neighbouring blocks.

Top module: `pci_dma_xlate`

## Requirements
- R1: While reset is high and in the first cycle after it, xl_hit, xl_miss, xl_sg, xl_win, xl_addr and cfg_err are all zero.
- R2: A request with req_dac=0 uses only req_addr[31:0]. It matches window i when window i is enabled and ((req_addr[31:20] XOR base_i) AND NOT mask_i) is zero. For a direct window (scatter-gather bit clear) xl_addr = (tba_i << 10) OR (req_addr[31:0] AND {mask_i, 20'hFFFFF}), with xl_sg=0 and xl_win=i.
- R3: On a hit in a window whose scatter-gather bit is set, xl_sg=1 and xl_addr = (tba_i << 10) + 8 * (window offset >> 13), where the window offset is the same masked value used in R2.
- R4: When several enabled windows match, xl_win reports the lowest-numbered one, and that window alone forms the address.
- R5: A window whose enable bit is clear never hits, and writing zero to its base, mask and translated-base registers disables it.
- R6: With the fixed window enabled, a request with req_dac=1 hits when req_addr[63:40] equals 24'h000001. It then reports xl_win=4 and xl_sg=0, with xl_addr = req_addr[34:0]; bits [39:35] have no effect. Programmable windows never match a request with req_dac=1.
- R7: When the fixed-window enable bit is clear, every request with req_dac=1 misses.
- R8: A request that matches nothing gives xl_miss=1 and zero on xl_hit, xl_sg, xl_win and xl_addr. A cycle with req_valid=0 gives zero on all five result outputs in the next cycle.
- R9: Results appear in the cycle after the request is presented. A register write takes effect for a request presented in the cycle right after the write.
- R10: A translated-base write with any wdata bit set outside [34:10] raises cfg_err for one cycle, in the cycle after the write. Only bits [34:10] are stored in either case.
- R11: cfg_addr = {window[1:0], kind[1:0]}, with kind 0 for base, 1 for mask, 2 for translated base and 3 for control. The base register holds bit 0 enable, bit 1 scatter-gather and bits [31:20] base. The mask register holds bits [31:20]. The control register holds bit 0, the fixed-window enable, and it is written for kind 3 with any window field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_dac | input | 1 | Request is a dual-address cycle |
| req_addr | input | 64 | PCI bus address |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select {window, kind} |
| cfg_wdata | input | 64 | Register write data |
| xl_hit | output | 1 | Registered: request hit a window |
| xl_win | output | 3 | Registered: winning window, 4 for the fixed window |
| xl_sg | output | 1 | Registered: xl_addr is a page-table entry address |
| xl_addr | output | 35 | Registered: system address or page-table entry address |
| xl_miss | output | 1 | Registered: request matched no window |
| cfg_err | output | 1 | Registered: illegal translated-base write pulse |

## Verification
Two cases are the hardest to reach from the ports. The first is overlap between enabled windows, because the firmware-like setup never produces it. The stimulus programs window 3 on top of window 1 and confirms that window 1 wins. It then clears window 1 register by register and watches the same address move to window 3. The second is a request issued in the very cycle after a register write. The write and request tasks are chained with no idle cycle, so a re-enabled fixed window and a rewritten translated base are observed on their first possible use. The edges of a window are covered by the stimulus table: the first byte, the last byte, the last page-table entry and the first address past the end.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  typedef enum logic [1:0] {
    KIND_BASE = 2'd0,
    KIND_MASK = 2'd1,
    KIND_TBA  = 2'd2,
    KIND_CTRL = 2'd3
  } pdx_kind_e;
endpackage

// File: rtl/pdx_regfile.sv
module pdx_regfile
  import pdx_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 64,
  parameter int SAC_W    = 32,
  parameter int GRAN_LSB = 20,
  parameter int SYS_W    = 35,
  parameter int TBA_LSB  = 10,
  parameter int WIN_W    = $clog2(NUM_WIN),
  parameter int WSEL_W   = WIN_W + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [WSEL_W-1:0]         waddr,
  input  logic [ADDR_W-1:0]         wdata,
  output logic [NUM_WIN-1:0]        en_o,
  output logic [NUM_WIN-1:0]        sg_o,
  output logic [SAC_W-1:GRAN_LSB]   base_o [NUM_WIN],
  output logic [SAC_W-1:GRAN_LSB]   mask_o [NUM_WIN],
  output logic [SYS_W-1:TBA_LSB]    tba_o  [NUM_WIN],
  output logic                      dac_en_o,
  output logic                      err_o
);
  localparam logic [ADDR_W-1:0] TBA_LEGAL =
    ((ADDR_W'(1) << SYS_W) - ADDR_W'(1)) & ~((ADDR_W'(1) << TBA_LSB) - ADDR_W'(1));

  pdx_kind_e        kind;
  logic [WIN_W-1:0] widx;

  assign kind = pdx_kind_e'(waddr[1:0]);
  assign widx = waddr[WSEL_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= '0;
      sg_o     <= '0;
      dac_en_o <= 1'b0;
      err_o    <= 1'b0;
      for (int i = 0; i < NUM_WIN; i++) begin
        base_o[i] <= '0;
        mask_o[i] <= '0;
        tba_o[i]  <= '0;
      end
    end else begin
      err_o <= 1'b0;
      if (we) begin
        unique case (kind)
          KIND_BASE: begin
            en_o[widx]   <= wdata[0];
            sg_o[widx]   <= wdata[1];
            base_o[widx] <= wdata[SAC_W-1:GRAN_LSB];
          end
          KIND_MASK: mask_o[widx] <= wdata[SAC_W-1:GRAN_LSB];
          KIND_TBA: begin
            tba_o[widx] <= wdata[SYS_W-1:TBA_LSB];
            err_o       <= |(wdata & ~TBA_LEGAL);
          end
          KIND_CTRL: dac_en_o <= wdata[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdx_win_match.sv
module pdx_win_match #(
  parameter int NUM_WIN  = 4,
  parameter int SAC_W    = 32,
  parameter int GRAN_LSB = 20
) (
  input  logic [SAC_W-1:GRAN_LSB] page_hi,
  input  logic [NUM_WIN-1:0]      en,
  input  logic [SAC_W-1:GRAN_LSB] base [NUM_WIN],
  input  logic [SAC_W-1:GRAN_LSB] mask [NUM_WIN],
  output logic [NUM_WIN-1:0]      match
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign match[g] = en[g] && (((page_hi ^ base[g]) & ~mask[g]) == '0);
  end
endmodule

// File: rtl/pdx_xlate.sv
module pdx_xlate #(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 64,
  parameter int SAC_W    = 32,
  parameter int GRAN_LSB = 20,
  parameter int SYS_W    = 35,
  parameter int TBA_LSB  = 10,
  parameter int PAGE_SH  = 13,
  parameter int PTE_SH   = 3,
  parameter int DAC_LSB  = 40,
  parameter logic [ADDR_W-DAC_LSB-1:0] DAC_TAG = 1,
  parameter int WIN_W    = $clog2(NUM_WIN),
  parameter int WIDX_W   = $clog2(NUM_WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_dac,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [NUM_WIN-1:0]      match,
  input  logic [NUM_WIN-1:0]      sg,
  input  logic [SAC_W-1:GRAN_LSB] mask [NUM_WIN],
  input  logic [SYS_W-1:TBA_LSB]  tba  [NUM_WIN],
  input  logic                    dac_en,
  output logic                    hit_q,
  output logic [WIDX_W-1:0]       win_q,
  output logic                    sg_q,
  output logic [SYS_W-1:0]        addr_q,
  output logic                    miss_q
);
  logic [WIN_W-1:0]  sel;
  logic              any;
  logic [SAC_W-1:0]  offset;
  logic [SYS_W-1:0]  tba_full;
  logic [SYS_W-1:0]  pte_step;
  logic [SYS_W-1:0]  win_addr;
  logic              dac_hit;
  logic              hit_d, sg_d, miss_d;
  logic [WIDX_W-1:0] win_d;
  logic [SYS_W-1:0]  addr_d;
  logic              unused_hole;

  // Lowest index wins: scan from the top so lower indices overwrite.
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel = WIN_W'(i);
        any = 1'b1;
      end
    end
  end

  assign offset   = {req_addr[SAC_W-1:GRAN_LSB] & mask[sel], req_addr[GRAN_LSB-1:0]};
  assign tba_full = {tba[sel], {TBA_LSB{1'b0}}};
  assign pte_step = SYS_W'(offset[SAC_W-1:PAGE_SH]) << PTE_SH;
  assign win_addr = sg[sel] ? (tba_full + pte_step) : (tba_full | SYS_W'(offset));
  assign dac_hit  = dac_en && (req_addr[ADDR_W-1:DAC_LSB] == DAC_TAG);
  assign unused_hole = ^req_addr[DAC_LSB-1:SYS_W];

  always_comb begin
    hit_d  = 1'b0;
    sg_d   = 1'b0;
    miss_d = 1'b0;
    win_d  = '0;
    addr_d = '0;
    if (req_valid) begin
      if (req_dac) begin
        if (dac_hit) begin
          hit_d  = 1'b1;
          win_d  = WIDX_W'(NUM_WIN);
          addr_d = req_addr[SYS_W-1:0];
        end else begin
          miss_d = 1'b1;
        end
      end else if (any) begin
        hit_d  = 1'b1;
        win_d  = WIDX_W'(sel);
        sg_d   = sg[sel];
        addr_d = win_addr;
      end else begin
        miss_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      win_q  <= '0;
      sg_q   <= 1'b0;
      addr_q <= '0;
      miss_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      win_q  <= win_d;
      sg_q   <= sg_d;
      addr_q <= addr_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate #(
  parameter int NUM_WIN  = 4,
  parameter int ADDR_W   = 64,
  parameter int SAC_W    = 32,
  parameter int GRAN_LSB = 20,
  parameter int SYS_W    = 35,
  parameter int TBA_LSB  = 10,
  parameter int PAGE_SH  = 13,
  parameter int PTE_SH   = 3,
  parameter int DAC_LSB  = 40,
  parameter logic [ADDR_W-DAC_LSB-1:0] DAC_TAG = 1,
  parameter int WIN_W    = $clog2(NUM_WIN),
  parameter int WSEL_W   = WIN_W + 2,
  parameter int WIDX_W   = $clog2(NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_dac,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_we,
  input  logic [WSEL_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              xl_hit,
  output logic [WIDX_W-1:0] xl_win,
  output logic              xl_sg,
  output logic [SYS_W-1:0]  xl_addr,
  output logic              xl_miss,
  output logic              cfg_err
);
  logic [NUM_WIN-1:0]      en_vec;
  logic [NUM_WIN-1:0]      sg_vec;
  logic [SAC_W-1:GRAN_LSB] base_arr [NUM_WIN];
  logic [SAC_W-1:GRAN_LSB] mask_arr [NUM_WIN];
  logic [SYS_W-1:TBA_LSB]  tba_arr  [NUM_WIN];
  logic                    dac_en;
  logic [NUM_WIN-1:0]      match_vec;

  pdx_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SAC_W(SAC_W), .GRAN_LSB(GRAN_LSB),
    .SYS_W(SYS_W), .TBA_LSB(TBA_LSB), .WIN_W(WIN_W), .WSEL_W(WSEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .en_o(en_vec), .sg_o(sg_vec), .base_o(base_arr), .mask_o(mask_arr),
    .tba_o(tba_arr), .dac_en_o(dac_en), .err_o(cfg_err)
  );

  pdx_win_match #(
    .NUM_WIN(NUM_WIN), .SAC_W(SAC_W), .GRAN_LSB(GRAN_LSB)
  ) u_match (
    .page_hi(req_addr[SAC_W-1:GRAN_LSB]), .en(en_vec), .base(base_arr),
    .mask(mask_arr), .match(match_vec)
  );

  pdx_xlate #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SAC_W(SAC_W), .GRAN_LSB(GRAN_LSB),
    .SYS_W(SYS_W), .TBA_LSB(TBA_LSB), .PAGE_SH(PAGE_SH), .PTE_SH(PTE_SH),
    .DAC_LSB(DAC_LSB), .DAC_TAG(DAC_TAG), .WIN_W(WIN_W), .WIDX_W(WIDX_W)
  ) u_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dac(req_dac),
    .req_addr(req_addr), .match(match_vec), .sg(sg_vec), .mask(mask_arr),
    .tba(tba_arr), .dac_en(dac_en), .hit_q(xl_hit), .win_q(xl_win),
    .sg_q(xl_sg), .addr_q(xl_addr), .miss_q(xl_miss)
  );
endmodule

// File: rtl/pdx_chk.sv
module pdx_chk #(
  parameter int NUM_WIN = 4,
  parameter int SYS_W   = 35,
  parameter int WIDX_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_dac,
  input logic [SYS_W-1:0]   addr_lo,
  input logic [NUM_WIN-1:0] win_en,
  input logic               hit,
  input logic               miss,
  input logic               sg,
  input logic [WIDX_W-1:0]  win,
  input logic [SYS_W-1:0]   xaddr
);
  localparam int EXT_W = 1 << WIDX_W;

  // Enable state seen by the request that produced the current result.
  logic [EXT_W-1:0] en_q;
  always_ff @(posedge clk) en_q <= EXT_W'({1'b1, win_en});

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
    miss |-> (xaddr == '0) && !sg && (win == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !hit && !miss && (xaddr == '0));

  p_dac_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dac) |=>
      (!hit || ((win == WIDX_W'(NUM_WIN)) && !sg && (xaddr == $past(addr_lo)))));

  p_enabled_only_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> en_q[win]);

  p_sg_window_r3: assert property (@(posedge clk) disable iff (rst)
    sg |-> hit && (win < WIDX_W'(NUM_WIN)));
endmodule

bind pci_dma_xlate pdx_chk #(
  .NUM_WIN(NUM_WIN), .SYS_W(SYS_W), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_dac(req_dac),
  .addr_lo(req_addr[SYS_W-1:0]), .win_en(en_vec), .hit(xl_hit),
  .miss(xl_miss), .sg(xl_sg), .win(xl_win), .xaddr(xl_addr)
);

// File: tb/sim_pci_dma_xlate.sv
`timescale 1ns/1ps
module sim_pci_dma_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_dac = 1'b0;
  logic [63:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        xl_hit, xl_sg, xl_miss, cfg_err;
  logic [2:0]  xl_win;
  logic [34:0] xl_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pci_dma_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dac(req_dac),
    .req_addr(req_addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .xl_hit(xl_hit), .xl_win(xl_win), .xl_sg(xl_sg),
    .xl_addr(xl_addr), .xl_miss(xl_miss), .cfg_err(cfg_err)
  );

  // {dac, addr, hit, win, sg, xaddr, miss}
  localparam int NV = 13;
  localparam logic [105:0] VEC [NV] = '{
    {1'b0, 64'h0000_0000_0080_0000, 1'b1, 3'd0, 1'b1, 35'h0_1234_5400, 1'b0},
    {1'b0, 64'h0000_0000_00FF_FFFF, 1'b1, 3'd0, 1'b1, 35'h0_1234_73F8, 1'b0},
    {1'b0, 64'h0000_0000_0100_0000, 1'b0, 3'd0, 1'b0, 35'h0,           1'b1},
    {1'b0, 64'h0000_0000_8000_1234, 1'b1, 3'd1, 1'b0, 35'h0_0000_1234, 1'b0},
    {1'b0, 64'h0000_0000_BFFF_FFFF, 1'b1, 3'd1, 1'b0, 35'h0_3FFF_FFFF, 1'b0},
    {1'b0, 64'h0000_0000_C000_2000, 1'b1, 3'd2, 1'b1, 35'h2_0000_0008, 1'b0},
    {1'b0, 64'hFFFF_FFFF_8000_0010, 1'b1, 3'd1, 1'b0, 35'h0_0000_0010, 1'b0},
    {1'b1, 64'h0000_01FD_5555_5555, 1'b1, 3'd4, 1'b0, 35'h5_5555_5555, 1'b0},
    {1'b1, 64'h0000_0300_0000_0000, 1'b0, 3'd0, 1'b0, 35'h0,           1'b1},
    {1'b1, 64'h0000_0000_8000_0000, 1'b0, 3'd0, 1'b0, 35'h0,           1'b1},
    {1'b1, 64'h0000_0100_0000_0000, 1'b1, 3'd4, 1'b0, 35'h0,           1'b0},
    {1'b0, 64'h0000_0000_0000_0000, 1'b0, 3'd0, 1'b0, 35'h0,           1'b1},
    {1'b0, 64'h0000_0000_FFFF_E000, 1'b1, 3'd2, 1'b1, 35'h2_000F_FFF8, 1'b0}
  };

  task automatic expect_out(input string req, input logic h, input logic [2:0] w,
                            input logic s, input logic [34:0] a, input logic m);
    checks++;
    if (xl_hit !== h || xl_win !== w || xl_sg !== s || xl_addr !== a || xl_miss !== m) begin
      errors++;
      $display("FAIL %s actual hit=%b win=%0d sg=%b addr=%h miss=%b expected hit=%b win=%0d sg=%b addr=%h miss=%b",
               req, xl_hit, xl_win, xl_sg, xl_addr, xl_miss, h, w, s, a, m);
    end
  endtask

  task automatic expect_err(input string req, input logic e);
    checks++;
    if (cfg_err !== e) begin
      errors++;
      $display("FAIL %s actual cfg_err=%b expected cfg_err=%b", req, cfg_err, e);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic access(input logic d, input logic [63:0] a);
    req_valid = 1'b1; req_dac = d; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_dac = 1'b0; req_addr = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 0, 0, 0, 35'h0, 0);
    expect_err("R1 in reset", 0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1 after reset", 0, 0, 0, 35'h0, 0);

    // R11 register map: cfg_addr = {window, kind}
    wr(4'h0, 64'h0000_0000_0080_0003);   // W0 base 8 MB, sg, en
    wr(4'h1, 64'h0000_0000_0070_0000);   // W0 size 8 MB
    wr(4'h2, 64'h0000_0000_1234_5400);
    wr(4'h4, 64'h0000_0000_8000_0001);   // W1 base 2 GB, direct
    wr(4'h5, 64'h0000_0000_3FF0_0000);   // W1 size 1 GB
    wr(4'h6, 64'h0);
    wr(4'h8, 64'h0000_0000_C000_0003);   // W2 base 3 GB, sg
    wr(4'h9, 64'h0000_0000_3FF0_0000);
    wr(4'hA, 64'h0000_0002_0000_0000);
    wr(4'h3, 64'h1);                      // fixed window on

    for (int k = 0; k < NV; k++) begin
      logic [105:0] v;
      string tag;
      v = VEC[k];
      if (v[105])      tag = "R6";
      else if (v[0])   tag = "R8";
      else if (v[36])  tag = "R3";
      else             tag = "R2";
      access(v[105], v[104:41]);
      expect_out(tag, v[40], v[39:37], v[36], v[35:1], v[0]);
    end

    // R8: idle cycle after a request clears all outputs
    @(negedge clk);
    expect_out("R8 idle", 0, 0, 0, 35'h0, 0);

    // R7 and R11: control written through window field 1, kind 3
    wr(4'h7, 64'h0);
    access(1'b1, 64'h0000_0100_0000_0040);
    expect_out("R7 fixed window off", 0, 0, 0, 35'h0, 1);
    wr(4'hB, 64'h1);
    access(1'b1, 64'h0000_0100_0000_0040);  // R9 used on the next cycle
    expect_out("R9 R11 fixed window re-enabled", 1, 4, 0, 35'h40, 0);

    // R4: W3 overlaps W1
    wr(4'hC, 64'h0000_0000_8000_0001);
    wr(4'hD, 64'h0000_0000_3FF0_0000);
    wr(4'hE, 64'h0000_0004_0000_0000);
    access(1'b0, 64'h0000_0000_8000_0040);
    expect_out("R4 lowest window wins", 1, 1, 0, 35'h40, 0);

    // R5: zero all W1 registers, request falls to W3
    wr(4'h4, 64'h0);
    wr(4'h5, 64'h0);
    wr(4'h6, 64'h0);
    access(1'b0, 64'h0000_0000_8000_0040);
    expect_out("R5 zeroed window skipped", 1, 3, 0, 35'h4_0000_0040, 0);
    wr(4'hC, 64'h0000_0000_8000_0000);   // enable bit clear
    access(1'b0, 64'h0000_0000_8000_0040);
    expect_out("R5 disabled window", 0, 0, 0, 35'h0, 1);

    // R10: illegal translated base bits
    wr(4'hA, 64'h0000_000F_0000_0408);
    expect_err("R10 illegal write flagged", 1);
    access(1'b0, 64'h0000_0000_C000_2000);
    expect_out("R10 R9 only legal bits stored", 1, 2, 1, 35'h7_0000_0408, 0);
    expect_err("R10 one-cycle pulse", 0);
    wr(4'hA, 64'h0000_0002_0000_0000);
    expect_err("R10 legal write", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule